// File: doc/BRIEF.md
# Complex Parallel Matched-Filter Correlator

This block compresses received pulses by correlating a complex baseband stream against a short complex reference. The reference is normally the first stretch of the transmitted linear FM sweep, stored conjugated and time-reversed, so that the output magnitude peaks when an echo lines up with the reference. Every clock may carry several consecutive samples, one per lane. The block keeps a sliding window of past samples so that each lane works out its own output sample from the same history, in the manner of a parallel sub-convolution.

Each complex product is split into four real multiply-accumulate chains, one for each pairing of real and imaginary parts. Per lane, the chains are reduced and registered, then merged into an in-phase sum (`rr − ii`) and a quadrature sum (`ri + ir`). A final stage scales each merged sum down by a fixed shift and saturates it to the 16-bit sample width. The coefficient set is written one tap at a time before streaming starts. A valid flag travels alongside the data through a fixed three-register pipeline.

Top module: `mfc_correlator`

## Requirements
- R1: While reset is high and on the first cycle after reset, `out_valid` is 0 and `out_re`/`out_im` are 0. Reset clears the sample history and all coefficients to zero.
- R2: For output sample n: `out_I[n] = sat(floor(S_I/2^OUT_SHIFT))` with `S_I = Σk (h_re[k]·x_re[n−k] − h_im[k]·x_im[n−k])`. Likewise `out_Q[n] = sat(floor(S_Q/2^OUT_SHIFT))` with `S_Q = Σk (h_re[k]·x_im[n−k] + h_im[k]·x_re[n−k])`. In both sums k runs over 0..TAPS−1, and samples before the first one after reset count as zero.
- R3: Lane j of each bus occupies bits `[16j+15:16j]`. On input, lane j of the m-th valid beat carries sample `n = LANES·m + j`, so lane 0 is the earliest. Output lane j of the m-th output beat carries `y[LANES·m + j]`.
- R4: `out_valid` rises on the second rising edge after the edge that samples `in_valid` high. Every valid input beat yields exactly one output beat.
- R5: Cycles with `in_valid` low leave the history unchanged. Results depend only on the sequence of valid beats and not on gaps between them.
- R6: While `out_valid` is low, `out_re` and `out_im` hold their previous values.
- R7: Values are signed two's complement. The scaling is an arithmetic right shift by OUT_SHIFT (default 15), which rounds toward minus infinity. The result then saturates to [−32768, 32767].
- R8: No internal sum wraps, even when all TAPS products are at full scale (−32768·−32768) in the same chain. Such inputs saturate the output to 32767 or −32768 according to the sign of the true sum.
- R9: A cycle with `coef_we` high writes `h[coef_idx] = (coef_re, coef_im)`, effective from the next edge. Taps that have not been written since reset stay zero. Coefficient writes never change the outputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | $clog2(TAPS) | Tap index written |
| coef_re | input | 16 | Real part of the written tap |
| coef_im | input | 16 | Imaginary part of the written tap |
| in_valid | input | 1 | Input beat valid |
| in_re | input | LANES·16 | Real parts of the input lanes |
| in_im | input | LANES·16 | Imaginary parts of the input lanes |
| out_valid | output | 1 | Output beat valid |
| out_re | output | LANES·16 | In-phase correlation per lane |
| out_im | output | LANES·16 | Quadrature correlation per lane |

## Verification
The bench loads full-scale coefficients and samples of both signs, including the doubly negative case where the quadrature sum reaches 2^36. An accumulator that is one bit too narrow would wrap there and show a small or wrongly signed value instead of the saturated rail. An impulse on lane 0 with a single nonzero tap exposes swapped lanes or a reversed window, because the response would appear in the wrong lane or the wrong beat. Random streams broken up by idle gaps catch a history that shifts on invalid cycles, since every later result would then be offset. Odd negative sums catch an output stage that rounds toward zero instead of flooring.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    localparam int SAMP_W = 16;
    localparam int COEF_W = 16;

    localparam logic signed [63:0] SAMP_MAX = (64'sd1 <<< (SAMP_W - 1)) - 64'sd1;
    localparam logic signed [63:0] SAMP_MIN = -(64'sd1 <<< (SAMP_W - 1));

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [COEF_W-1:0] re;
        logic signed [COEF_W-1:0] im;
    } coef_t;

    // Width that holds a difference of two sums of `taps` full-scale products.
    function automatic int acc_width(input int taps);
        return SAMP_W + COEF_W + $clog2(taps) + 1;
    endfunction

    // Arithmetic down-shift (floor) followed by clamp to the sample range.
    function automatic logic signed [SAMP_W-1:0] shift_sat(input logic signed [63:0] v,
                                                           input int sh);
        logic signed [63:0] s;
        s = v >>> sh;
        if (s > SAMP_MAX)      s = SAMP_MAX;
        else if (s < SAMP_MIN) s = SAMP_MIN;
        return s[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/mfc_coef_bank.sv
module mfc_coef_bank import mfc_pkg::*; #(
    parameter int TAPS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(TAPS)-1:0] idx,
    input  logic [COEF_W-1:0]       c_re,
    input  logic [COEF_W-1:0]       c_im,
    output coef_t [TAPS-1:0]        taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (we) begin
            taps[idx].re <= c_re;
            taps[idx].im <= c_im;
        end
    end

endmodule

// File: rtl/mfc_window.sv
module mfc_window import mfc_pkg::*; #(
    parameter int LANES = 4,
    parameter int TAPS  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  samp_t [LANES-1:0]          beat,
    output samp_t [TAPS+LANES-2:0]     win
);

    localparam int HIST = TAPS + LANES - 1;

    // win[0] is the newest sample; index grows toward the past.
    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
        end else if (shift_en) begin
            for (int i = HIST - 1; i >= LANES; i--) begin
                win[i] <= win[i-LANES];
            end
            for (int j = 0; j < LANES; j++) begin
                win[LANES-1-j] <= beat[j];
            end
        end
    end

endmodule

// File: rtl/mfc_lane.sv
module mfc_lane import mfc_pkg::*; #(
    parameter int TAPS  = 32,
    parameter int ACC_W = 38
) (
    input  logic                    clk,
    input  logic                    rst,
    input  samp_t [TAPS-1:0]        seg,
    input  coef_t [TAPS-1:0]        taps,
    output logic signed [ACC_W-1:0] rr_q,
    output logic signed [ACC_W-1:0] ii_q,
    output logic signed [ACC_W-1:0] ri_q,
    output logic signed [ACC_W-1:0] ir_q
);

    logic signed [ACC_W-1:0] rr_d, ii_d, ri_d, ir_d;

    // Four real correlators; seg[k] is x[n-k], taps[k] is h[k].
    always_comb begin
        rr_d = '0;
        ii_d = '0;
        ri_d = '0;
        ir_d = '0;
        for (int k = 0; k < TAPS; k++) begin
            rr_d = rr_d + ACC_W'(seg[k].re) * ACC_W'(taps[k].re);
            ii_d = ii_d + ACC_W'(seg[k].im) * ACC_W'(taps[k].im);
            ri_d = ri_d + ACC_W'(seg[k].re) * ACC_W'(taps[k].im);
            ir_d = ir_d + ACC_W'(seg[k].im) * ACC_W'(taps[k].re);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
            ii_q <= '0;
            ri_q <= '0;
            ir_q <= '0;
        end else begin
            rr_q <= rr_d;
            ii_q <= ii_d;
            ri_q <= ri_d;
            ir_q <= ir_d;
        end
    end

endmodule

// File: rtl/mfc_combine.sv
module mfc_combine import mfc_pkg::*; #(
    parameter int ACC_W     = 38,
    parameter int OUT_SHIFT = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] rr,
    input  logic signed [ACC_W-1:0] ii,
    input  logic signed [ACC_W-1:0] ri,
    input  logic signed [ACC_W-1:0] ir,
    output samp_t                   y
);

    logic signed [ACC_W-1:0] i_full, q_full;

    assign i_full = rr - ii;
    assign q_full = ri + ir;

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (load) begin
            y.re <= shift_sat(64'(i_full), OUT_SHIFT);
            y.im <= shift_sat(64'(q_full), OUT_SHIFT);
        end
    end

endmodule

// File: rtl/mfc_correlator.sv
module mfc_correlator import mfc_pkg::*; #(
    parameter int LANES     = 4,
    parameter int TAPS      = 32,
    parameter int OUT_SHIFT = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_idx,
    input  logic [COEF_W-1:0]         coef_re,
    input  logic [COEF_W-1:0]         coef_im,
    input  logic                      in_valid,
    input  logic [LANES*SAMP_W-1:0]   in_re,
    input  logic [LANES*SAMP_W-1:0]   in_im,
    output logic                      out_valid,
    output logic [LANES*SAMP_W-1:0]   out_re,
    output logic [LANES*SAMP_W-1:0]   out_im
);

    localparam int ACC_W = acc_width(TAPS);
    localparam int HIST  = TAPS + LANES - 1;

    samp_t [LANES-1:0] beat;
    samp_t [HIST-1:0]  win;
    coef_t [TAPS-1:0]  taps;
    samp_t [LANES-1:0] lane_out;
    logic              v_hist, v_sum;

    mfc_coef_bank #(.TAPS(TAPS)) u_coef (
        .clk  (clk),
        .rst  (rst),
        .we   (coef_we),
        .idx  (coef_idx),
        .c_re (coef_re),
        .c_im (coef_im),
        .taps (taps)
    );

    mfc_window #(.LANES(LANES), .TAPS(TAPS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .beat     (beat),
        .win      (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_hist    <= 1'b0;
            v_sum     <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_hist    <= in_valid;
            v_sum     <= v_hist;
            out_valid <= v_sum;
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        samp_t [TAPS-1:0]        seg;
        logic signed [ACC_W-1:0] rr, ii, ri, ir;

        assign beat[j].re = in_re[j*SAMP_W +: SAMP_W];
        assign beat[j].im = in_im[j*SAMP_W +: SAMP_W];

        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign seg[k] = win[LANES-1-j+k];
        end

        mfc_lane #(.TAPS(TAPS), .ACC_W(ACC_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .seg  (seg),
            .taps (taps),
            .rr_q (rr),
            .ii_q (ii),
            .ri_q (ri),
            .ir_q (ir)
        );

        mfc_combine #(.ACC_W(ACC_W), .OUT_SHIFT(OUT_SHIFT)) u_comb (
            .clk  (clk),
            .rst  (rst),
            .load (v_sum),
            .rr   (rr),
            .ii   (ii),
            .ri   (ri),
            .ir   (ir),
            .y    (lane_out[j])
        );

        assign out_re[j*SAMP_W +: SAMP_W] = lane_out[j].re;
        assign out_im[j*SAMP_W +: SAMP_W] = lane_out[j].im;
    end

endmodule

// File: rtl/mfc_correlator_chk.sv
module mfc_correlator_chk #(
    parameter int BUS_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [BUS_W-1:0] out_re,
    input logic [BUS_W-1:0] out_im
);

    logic [2:0] vd;

    always_ff @(posedge clk) begin
        if (rst) vd <= '0;
        else     vd <= {vd[1:0], in_valid};
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_re == '0 && out_im == '0));

    p_valid_delay_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vd[2]);

    p_valid_known_r4: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(out_valid));

    p_hold_re_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_re));

    p_hold_im_r6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_im));

endmodule

bind mfc_correlator mfc_correlator_chk #(.BUS_W(LANES*mfc_pkg::SAMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/mfc_correlator_test.sv
module mfc_correlator_test;

    localparam int LANES = 4;
    localparam int TAPS  = 32;
    localparam int SH    = 15;
    localparam int W     = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 coef_we = 1'b0;
    logic [4:0]           coef_idx = '0;
    logic [W-1:0]         coef_re = '0, coef_im = '0;
    logic                 in_valid = 1'b0;
    logic [LANES*W-1:0]   in_re = '0, in_im = '0;
    logic                 out_valid;
    logic [LANES*W-1:0]   out_re, out_im;

    mfc_correlator #(.LANES(LANES), .TAPS(TAPS), .OUT_SHIFT(SH)) uut (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_re(coef_re), .coef_im(coef_im), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0, checks = 0;
    int hr[TAPS], hi[TAPS];
    int xr[$], xi[$], in_cyc[$];
    int ocount = 0;
    logic [LANES*W-1:0] last_re = '0, last_im = '0;
    logic [31:0] seed = 32'h1234_5678;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    function automatic longint sat(input longint v);
        longint s;
        s = v >>> SH;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    function automatic void model(input int n, output longint ei, output longint eq);
        longint si = 0, sq = 0;
        for (int k = 0; k < TAPS; k++) begin
            int m = n - k;
            if (m >= 0) begin
                si += longint'(hr[k]) * xr[m] - longint'(hi[k]) * xi[m];
                sq += longint'(hr[k]) * xi[m] + longint'(hi[k]) * xr[m];
            end
        end
        ei = sat(si);
        eq = sat(sq);
    endfunction

    // Output monitor: compares at negedge, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (ocount >= in_cyc.size()) begin
                    chk(0, "R4 spurious output beat", ocount, in_cyc.size());
                end else begin
                    chk(cyc == in_cyc[ocount] + 2, "R4 latency cycle", cyc, in_cyc[ocount] + 2);
                    for (int j = 0; j < LANES; j++) begin
                        longint ei, eq, ai, aq;
                        model(ocount * LANES + j, ei, eq);
                        ai = longint'($signed(out_re[j*W +: W]));
                        aq = longint'($signed(out_im[j*W +: W]));
                        chk(ai == ei, "R2/R3/R7/R8 in-phase lane", ai, ei);
                        chk(aq == eq, "R2/R3/R7/R8 quadrature lane", aq, eq);
                    end
                end
                ocount++;
            end else begin
                chk(out_re == last_re, "R6 hold re", longint'(out_re[W-1:0]), longint'(last_re[W-1:0]));
                chk(out_im == last_im, "R6 hold im", longint'(out_im[W-1:0]), longint'(last_im[W-1:0]));
            end
            last_re = out_re;
            last_im = out_im;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        coef_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        xr.delete(); xi.delete(); in_cyc.delete();
        ocount = 0;
        last_re = '0; last_im = '0;
        for (int k = 0; k < TAPS; k++) begin hr[k] = 0; hi[k] = 0; end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_tap(input int k, input int re, input int im);
        coef_we  = 1'b1;
        coef_idx = 5'(k);
        coef_re  = W'(re);
        coef_im  = W'(im);
        @(negedge clk);
        coef_we  = 1'b0;
        hr[k] = re;
        hi[k] = im;
    endtask

    // mode 0: random, mode 1: constant (a,b), mode 2: impulse (a,b) on lane 0
    task automatic beat(input int mode, input int a, input int b);
        for (int j = 0; j < LANES; j++) begin
            int vr, vi;
            if (mode == 0)      begin vr = rnd16(); vi = rnd16(); end
            else if (mode == 1) begin vr = a; vi = b; end
            else                begin vr = (j == 0) ? a : 0; vi = (j == 0) ? b : 0; end
            in_re[j*W +: W] = W'(vr);
            in_im[j*W +: W] = W'(vi);
            xr.push_back(vr);
            xi.push_back(vi);
        end
        in_valid = 1'b1;
        in_cyc.push_back(cyc + 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_re = '0;
        in_im = '0;
    endtask

    task automatic drain_and_count(input string tag);
        idle(5);
        chk(ocount == in_cyc.size(), tag, ocount, in_cyc.size());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        do_reset();
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(out_re == '0 && out_im == '0, "R1 outputs zero", longint'(out_re[W-1:0]), 0);

        // R9: unwritten taps are zero, so random data gives zero output
        for (int b = 0; b < 3; b++) beat(0, 0, 0);
        drain_and_count("R9/R4 beats with zero taps");

        // R9/R3: single tap, impulse on lane 0 shows where the response lands
        do_reset();
        write_tap(3, 10000, -5000);
        beat(2, 20000, 7000);
        for (int b = 0; b < 10; b++) beat(1, 0, 0);
        drain_and_count("R9/R3 impulse beats");

        // R2/R5/R7: random taps, random stream with gaps
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, rnd16(), rnd16());
        for (int b = 0; b < 40; b++) begin
            beat(0, 0, 0);
            idle(b % 3);
        end
        drain_and_count("R5 random gapped stream beats");

        // R2: back-to-back random stream, second coefficient set
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, rnd16() / 4, rnd16());
        for (int b = 0; b < 30; b++) beat(0, 0, 0);
        drain_and_count("R2 back-to-back beats");

        // R8: full-scale positive saturation on I
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, -32768, 0);
        for (int b = 0; b < 10; b++) beat(1, -32768, 0);
        drain_and_count("R8 full-scale I beats");
        chk(longint'($signed(out_re[W-1:0])) == 32767, "R8 I rail",
            longint'($signed(out_re[W-1:0])), 32767);

        // R8: negative saturation
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, 32767, 0);
        for (int b = 0; b < 10; b++) beat(1, -32768, 0);
        drain_and_count("R8 negative rail beats");
        chk(longint'($signed(out_re[W-1:0])) == -32768, "R8 I negative rail",
            longint'($signed(out_re[W-1:0])), -32768);

        // R8: quadrature sum at 2^36
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, -32768, -32768);
        for (int b = 0; b < 10; b++) beat(1, -32768, -32768);
        drain_and_count("R8 full-scale Q beats");
        chk(longint'($signed(out_im[W-1:0])) == 32767, "R8 Q rail",
            longint'($signed(out_im[W-1:0])), 32767);

        // R7: small negative sums exercise flooring
        do_reset();
        for (int k = 0; k < TAPS; k++) write_tap(k, (k % 2 == 0) ? -3 : 5, 1);
        for (int b = 0; b < 12; b++) beat(0, 0, 0);
        drain_and_count("R7 small-value beats");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule